// File: doc/BRIEF.md
# Iterative Reciprocal Square Root Engine

The block computes 1/sqrt(x) for an unsigned fixed-point sample with Newton-Raphson refinement. It runs on a fast clock, while samples arrive at a slower base rate, one every `ITERS` clocks. A single iteration datapath is shared across those clocks. Each clock performs exactly one refinement step of the form y' = y * (3 - m*y*y) / 2 for the sample in flight.

A leading-one detector normalises the input by an even shift, so the mantissa m falls in [1, 4). A small table, computed when the design is elaborated, gives a starting estimate of 1/sqrt(m). After the last step, the result is shifted back by half the normalising shift and rounded to the output format.

Samples come in with a one-cycle `inValid` strobe. Results leave with a one-cycle `outValid` strobe after a fixed latency. Once the pipeline is full, the block produces one result per accepted sample.

The parameters must satisfy these rules: `IN_W` and `IN_FRAC` are even, and `SEED_BITS` is between 3 and `IN_W`. The defaults are `ITERS`=3, a 16-bit input with 8 fraction bits, a 16-bit output with 11 fraction bits, and a 16-entry seed table.

Top module: `rsqrt_iter`

## Requirements
- R1: For a nonzero input X (value X/2^IN_FRAC), `outData` lies within 2 LSB of round(2^OUT_FRAC / sqrt(X/2^IN_FRAC)). The normalised mantissa has a leading one in its top two bits, and the seed lies in [0.5, 1].
- R2: A zero input produces the all-ones output code (65535 with defaults).
- R3: `outValid` rises on the (ITERS+2)-th rising edge, counting the edge that samples `inValid` as the first. With defaults, this is the 5th edge.
- R4: Every accepted sample yields exactly one `outValid` pulse. The pulse lasts one cycle. Results leave in input order.
- R5: Samples spaced exactly ITERS clocks apart are all accepted, and their results emerge ITERS clocks apart. The single iteration datapath never starts a new sample and steps an older one in the same cycle.
- R6: An `inValid` strobe that arrives fewer than ITERS clocks after the last accepted strobe is ignored and produces no result.
- R7: Between `outValid` pulses, `outData` holds the last result.
- R8: While reset is asserted, `outValid` and `outData` are 0.
- R9: Exact powers of four within range give exact codes. With defaults: x=1 gives 2048, x=4 gives 1024, x=16 gives 512, x=64 gives 256, and x=1/4 gives 4096.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, ITERS times the sample rate |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Sample strobe |
| inData | input | IN_W | Unsigned input, IN_FRAC fraction bits |
| outValid | output | 1 | Result strobe, one cycle |
| outData | output | OUT_W | Unsigned result, OUT_FRAC fraction bits |

## Verification
Several properties are checked on every cycle:
- The iteration datapath is never claimed twice in the same cycle.
- A start is followed by a step, or by the output load.
- Result pulses are single-cycle.
- A normalised mantissa always has a leading one in its top two bits.
- Every seed lies in [0.5, 1].
- A zero sample always lands on the saturated code.

Only the bench scenarios can show the rest:
- Numerical accuracy against a real-valued reference.
- The exact end-to-end latency.
- The dropping of early strobes, counted by results.
- The holding of the output between results.
- Exact codes at powers of four.

// File: rtl/rsqrt_pkg.sv
`timescale 1ns/1ps
package rsqrt_pkg;

  typedef struct packed {
    logic loadSeed;
    logic startIter;
    logic stepIter;
    logic loadOut;
  } ctrl_t;

  function automatic longint unsigned isqrt64(input longint unsigned v);
    longint unsigned res;
    longint unsigned cand;
    res = 0;
    for (int b = 31; b >= 0; b--) begin
      cand = res | (64'd1 << b);
      if (cand * cand <= v) res = cand;
    end
    return res;
  endfunction

  // Seed for mantissa bucket idx (Q2.(sb-2)), taken at the bucket midpoint:
  // 2^fb / sqrt((idx+0.5)/2^(sb-2)) = sqrt(2^(2fb+sb-1) / (2idx+1))
  function automatic longint unsigned seedValue(input int idx, input int fb, input int sb);
    longint unsigned num;
    if (idx < (1 << (sb - 2))) return 0;
    num = (64'd1 << (2 * fb + sb - 1)) / longint'(2 * idx + 1);
    return isqrt64(num);
  endfunction

endpackage

// File: rtl/rsqrt_seed.sv
`timescale 1ns/1ps
module rsqrt_seed
  import rsqrt_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int FB        = 17,
  parameter int SEED_BITS = 4
) (
  input  logic [IN_W-1:0]         xRaw,
  output logic [IN_W-1:0]         mNorm,
  output logic [FB+1:0]           ySeed,
  output logic [$clog2(IN_W)-1:0] halfSh,
  output logic                    isZero
);
  localparam int YW   = FB + 2;
  localparam int HW   = $clog2(IN_W);
  localparam int NTAB = 1 << SEED_BITS;

  logic [YW-1:0] seedTab [NTAB];
  int lead;
  int shEven;

  for (genvar g = 0; g < NTAB; g++) begin : g_seed
    localparam longint unsigned SV = seedValue(g, FB, SEED_BITS);
    assign seedTab[g] = YW'(SV);
  end

  always_comb begin
    lead = 0;
    for (int i = 0; i < IN_W; i++) begin
      if (xRaw[i]) lead = i;
    end
    shEven = (IN_W - 1 - lead) & ~1;
    mNorm  = xRaw << shEven;
    halfSh = HW'(shEven / 2);
    isZero = (xRaw == '0);
  end

  assign ySeed = seedTab[mNorm[IN_W-1 -: SEED_BITS]];

endmodule

// File: rtl/rsqrt_ctrl.sv
`timescale 1ns/1ps
module rsqrt_ctrl
  import rsqrt_pkg::*;
#(
  parameter int ITERS = 3
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  inValid,
  output ctrl_t ctl,
  output logic  outValid
);
  localparam int CW = $clog2(ITERS + 1);

  logic [CW-1:0] gapQ;
  logic [CW-1:0] remQ;
  logic          seedQ;
  logic          doneQ;
  logic          accept;
  logic          lastIter;

  assign accept   = inValid && (gapQ == '0);
  assign lastIter = (seedQ && (ITERS == 1)) || (remQ == CW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapQ     <= '0;
      remQ     <= '0;
      seedQ    <= 1'b0;
      doneQ    <= 1'b0;
      outValid <= 1'b0;
    end else begin
      if (accept)            gapQ <= CW'(ITERS - 1);
      else if (gapQ != '0)   gapQ <= gapQ - 1'b1;
      if (seedQ)             remQ <= CW'(ITERS - 1);
      else if (remQ != '0)   remQ <= remQ - 1'b1;
      seedQ    <= accept;
      doneQ    <= lastIter;
      outValid <= doneQ;
    end
  end

  always_comb begin
    ctl.loadSeed  = accept;
    ctl.startIter = seedQ;
    ctl.stepIter  = (remQ != '0);
    ctl.loadOut   = doneQ;
  end

  AST_ENGINE_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(ctl.startIter && ctl.stepIter)); // R5

  if (ITERS > 1) begin : g_multi
    AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rstN) outValid |=> !outValid); // R4
    AST_START_STEP: assert property (@(posedge clk) disable iff (!rstN) ctl.startIter |=> ctl.stepIter); // R3
  end else begin : g_single
    AST_START_OUT: assert property (@(posedge clk) disable iff (!rstN) ctl.startIter |=> ctl.loadOut); // R3
  end

endmodule

// File: rtl/rsqrt_datapath.sv
`timescale 1ns/1ps
module rsqrt_datapath
  import rsqrt_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int IN_FRAC   = 8,
  parameter int OUT_W     = 16,
  parameter int OUT_FRAC  = 11,
  parameter int SEED_BITS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctl,
  input  logic [IN_W-1:0]  inData,
  output logic [OUT_W-1:0] outData
);
  localparam int FB    = OUT_FRAC + IN_FRAC / 2 + 2;
  localparam int YW    = FB + 2;
  localparam int MF    = IN_W - 2;
  localparam int PW    = 2 * YW + IN_W;
  localparam int HW    = $clog2(IN_W);
  localparam int TBASE = FB - OUT_FRAC + (IN_W - 2 - IN_FRAC) / 2;
  localparam logic [YW-1:0] YLO  = YW'(1) << (FB - 1);
  localparam logic [YW-1:0] YHI  = YW'(1) << FB;
  localparam logic [PW-1:0] OMAX = {{(PW-OUT_W){1'b0}}, {OUT_W{1'b1}}};

  logic [IN_W-1:0] mNorm;
  logic [YW-1:0]   ySeed;
  logic [HW-1:0]   halfSh;
  logic            isZero;

  logic [IN_W-1:0] mSeedQ, mIterQ;
  logic [YW-1:0]   ySeedQ, yIterQ;
  logic [HW-1:0]   hSeedQ, hIterQ;
  logic            zSeedQ, zIterQ;
  logic [OUT_W-1:0] outQ;

  logic [IN_W-1:0] mEng;
  logic [YW-1:0]   yEng;
  logic [PW-1:0]   sq, prod, diff;
  logic [YW-1:0]   yNext;
  logic [PW-1:0]   rnd;
  logic [OUT_W-1:0] finalVal;
  int              shAmt;

  rsqrt_seed #(.IN_W(IN_W), .FB(FB), .SEED_BITS(SEED_BITS)) seed_i (
    .xRaw  (inData),
    .mNorm (mNorm),
    .ySeed (ySeed),
    .halfSh(halfSh),
    .isZero(isZero)
  );

  // One Newton-Raphson step, shared by every iteration of every sample
  always_comb begin
    mEng  = ctl.startIter ? mSeedQ : mIterQ;
    yEng  = ctl.startIter ? ySeedQ : yIterQ;
    sq    = (PW'(yEng) * PW'(yEng)) >> FB;
    prod  = (PW'(mEng) * sq) >> MF;
    diff  = (PW'(3) << FB) - prod;
    yNext = YW'((PW'(yEng) * diff) >> (FB + 1));
  end

  // Denormalise and round to the output format
  always_comb begin
    shAmt = TBASE - int'(hIterQ);
    rnd   = (PW'(yIterQ) + (PW'(1) << (shAmt - 1))) >> shAmt;
    if (zIterQ || (rnd > OMAX)) finalVal = '1;
    else                        finalVal = rnd[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSeedQ <= '0;
      ySeedQ <= '0;
      hSeedQ <= '0;
      zSeedQ <= 1'b0;
      mIterQ <= '0;
      yIterQ <= '0;
      hIterQ <= '0;
      zIterQ <= 1'b0;
      outQ   <= '0;
    end else begin
      if (ctl.loadSeed) begin
        mSeedQ <= mNorm;
        ySeedQ <= ySeed;
        hSeedQ <= halfSh;
        zSeedQ <= isZero;
      end
      if (ctl.startIter) begin
        mIterQ <= mSeedQ;
        hIterQ <= hSeedQ;
        zIterQ <= zSeedQ;
        yIterQ <= yNext;
      end else if (ctl.stepIter) begin
        yIterQ <= yNext;
      end
      if (ctl.loadOut) outQ <= finalVal;
    end
  end

  assign outData = outQ;

  AST_MANT_NORM: assert property (@(posedge clk) disable iff (!rstN) (ctl.startIter && !zSeedQ) |-> (mSeedQ[IN_W-1 -: 2] != 2'b00)); // R1
  AST_SEED_RANGE: assert property (@(posedge clk) disable iff (!rstN) (ctl.startIter && !zSeedQ) |-> ((ySeedQ >= YLO) && (ySeedQ <= YHI))); // R1
  AST_ZERO_SAT: assert property (@(posedge clk) disable iff (!rstN) (ctl.loadOut && zIterQ) |=> (outQ == '1)); // R2

endmodule

// File: rtl/rsqrt_iter.sv
`timescale 1ns/1ps
module rsqrt_iter
  import rsqrt_pkg::*;
#(
  parameter int ITERS     = 3,
  parameter int IN_W      = 16,
  parameter int IN_FRAC   = 8,
  parameter int OUT_W     = 16,
  parameter int OUT_FRAC  = 11,
  parameter int SEED_BITS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inData,
  output logic             outValid,
  output logic [OUT_W-1:0] outData
);
  ctrl_t ctl;

  rsqrt_ctrl #(.ITERS(ITERS)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .ctl     (ctl),
    .outValid(outValid)
  );

  rsqrt_datapath #(
    .IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_W(OUT_W),
    .OUT_FRAC(OUT_FRAC), .SEED_BITS(SEED_BITS)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .inData (inData),
    .outData(outData)
  );

endmodule

// File: tb/rsqrt_iter_tb_top.sv
`timescale 1ns/1ps
module rsqrt_iter_tb_top;
  localparam int ITERS    = 3;
  localparam int IN_W     = 16;
  localparam int IN_FRAC  = 8;
  localparam int OUT_W    = 16;
  localparam int OUT_FRAC = 11;
  localparam int LAT      = ITERS + 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [IN_W-1:0]  inData = '0;
  logic             outValid;
  logic [OUT_W-1:0] outData;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int expQ [0:2047];
  int edgeQ[0:2047];
  int kindQ[0:2047];
  int head = 0;
  int tail = 0;
  int lastAcc = -1000;
  int accCount = 0;
  int outCount = 0;
  bit prevValid = 1'b0;
  bit seenOut = 1'b0;
  int lastOut = 0;
  bit done = 1'b0;

  rsqrt_iter #(
    .ITERS(ITERS), .IN_W(IN_W), .IN_FRAC(IN_FRAC),
    .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC), .SEED_BITS(4)
  ) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int refOut(input int x);
    real r;
    int v;
    if (x == 0) return (1 << OUT_W) - 1;
    r = (2.0 ** OUT_FRAC) / $sqrt(real'(x) / (2.0 ** IN_FRAC));
    v = $rtoi(r + 0.5);
    if (v > (1 << OUT_W) - 1) v = (1 << OUT_W) - 1;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 = tolerance (R1), 1 = exact power of four (R9), 2 = zero (R2)
  task automatic drive(input int x, input int kind);
    @(negedge clk);
    inValid = 1'b1;
    inData  = IN_W'(x);
    if (cyc + 1 - lastAcc >= ITERS) begin
      expQ[tail]  = refOut(x);
      kindQ[tail] = kind;
      edgeQ[tail] = cyc + 1;
      tail++;
      lastAcc = cyc + 1;
      accCount++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    int d;
    if (rstN) begin
      if (outValid) begin
        check(!prevValid, "R4 single-cycle pulse", 1, 0);
        if (head == tail) begin
          check(1'b0, "R6 result without accepted sample", int'(outData), -1);
        end else begin
          d = int'(outData) - expQ[head];
          if (d < 0) d = -d;
          if (kindQ[head] == 2)      check(d == 0, "R2 zero saturation", int'(outData), expQ[head]);
          else if (kindQ[head] == 1) check(d == 0, "R9 exact power of four", int'(outData), expQ[head]);
          else                       check(d <= 2, "R1 value within 2 LSB", int'(outData), expQ[head]);
          check(cyc == edgeQ[head] + LAT - 1, "R3 R5 latency and cadence", cyc - edgeQ[head] + 1, LAT);
          head++;
        end
        outCount++;
        lastOut = int'(outData);
        seenOut = 1'b1;
      end else if (seenOut) begin
        check(int'(outData) == lastOut, "R7 output hold", int'(outData), lastOut);
      end
      prevValid = outValid;
    end
  end

  initial begin
    int base;
    int x;
    int dir [7];
    int dk  [7];
    void'($urandom(32'd4242));
    dir = '{0, 256, 1024, 4096, 16384, 64, 1};
    dk  = '{2, 1, 1, 1, 1, 1, 0};
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R8 reset outValid", int'(outValid), 0);
    check(outData == '0, "R8 reset outData", int'(outData), 0);
    rstN = 1'b1;
    idle(2);

    // Directed corners at exactly ITERS spacing (R2, R9, R5)
    for (int i = 0; i < 7; i++) begin
      drive(dir[i], dk[i]);
      idle(ITERS - 1);
    end
    drive(65535, 0);
    idle(12);

    // Early strobe is dropped (R6)
    base = outCount;
    drive(300, 0);
    drive(5000, 0);
    idle(1);
    drive(777, 0);
    idle(12);
    check(outCount - base == 2, "R6 early strobe ignored", outCount - base, 2);

    // Random values, legal spacing (R1, R5)
    for (int i = 0; i < 300; i++) begin
      x = int'($urandom & 32'hFFFF);
      if (($urandom % 4) == 0) x = int'($urandom % 256);
      drive(x, 0);
      idle(ITERS - 1 + int'($urandom % 3));
    end
    idle(12);

    // Random values with some early strobes (R6, R4)
    for (int i = 0; i < 100; i++) begin
      x = int'($urandom & 32'hFFFF);
      drive(x, 0);
      idle(int'($urandom % ITERS));
    end
    idle(15);

    check(outCount == accCount, "R4 one result per accepted sample", outCount, accCount);
    check(head == tail, "R4 all results delivered", head, tail);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule